// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block is a register-mapped arithmetic peripheral. A bus master sets a 16-bit control word and loads two operands, each of which can be 16 or 32 bits wide. The operation starts when the master writes the second operand. The unit can run an unsigned or signed multiply, which overwrites the 64-bit result. It can also run an unsigned or signed multiply-accumulate, which adds the product to the 64-bit result already held. The result is read back as four 16-bit words.

Two options alter the arithmetic. A fractional option doubles the product. A saturation option clamps a signed accumulate that overflows. A carry flag holds the bit above the result, and software can write it. The unit commits one result word per clock, so the low half of the result is valid before the high half. A write interlock can stall bus writes until either the low 32 bits or all 64 bits of the result are valid. This lets a master reload operands right after starting an operation without disturbing it.

Top module: `mac16_unit`

## Requirements
- R1: After reset, every control field reads 0 and all four result words read 0. Control bits 15..10 and bit 1 always read 0, whatever value was written to them.
- R2: The word addresses are fixed. Address 0 is control. Addresses 1 and 2 hold the low and high halves of operand A. Addresses 3 and 4 hold the low and high halves of operand B. Addresses 5 to 8 hold result words 0 (least significant) to 3. The control fields are: bit 0 carry, bit 2 fractional, bit 3 saturate, bits 5:4 mode (00 unsigned multiply, 01 signed multiply, 10 unsigned accumulate, 11 signed accumulate), bit 6 operand A is 32 bits, bit 7 operand B is 32 bits, bit 8 write interlock on, bit 9 interlock releases at the 32-bit point.
- R3: A write to the top word of operand B starts an operation. That word is address 3 when B is 16 bits and address 4 when B is 32 bits. A 16-bit operand uses only its low half, extended with zeros, or with its sign in the signed modes. The multiply modes replace the 64-bit result with the product.
- R4: The accumulate modes add the product to the current 64-bit result. The result words are writable, which lets software preload the accumulator.
- R5: When both fractional and saturate are off, an operation sets the carry to bit 64 of the sum. The sum is taken with both terms extended to 65 bits: zero-extended in the unsigned modes, sign-extended in the signed modes. In the multiply modes the accumulator term is zero.
- R6: Fractional mode shifts the product left by one bit. While fractional or saturate is set, operations leave the carry unchanged. A control write sets the carry directly.
- R7: In signed accumulate mode with saturate set, a sum that overflows is clamped. A positive overflow gives 0x7FFF_FFFF_FFFF_FFFF and a negative overflow gives 0x8000_0000_0000_0000.
- R8: After the clock edge that starts an operation, result word k takes its new value at the (k+1)-th following edge.
- R9: With the interlock on, a write stalls while the selected part of the result is still pending. For a write presented in the cycle after the start, the stall lasts 4 cycles when releasing at 64 bits and 2 cycles when releasing at 32 bits. The held write then takes effect.
- R10: With the interlock off, writes never stall, and reads never stall in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| bus_stall | output | 1 | Holds the current write; the master keeps the request stable while this is high |

## Verification
The assertions assume that a master facing a stall keeps the same write request until the stall clears. They also assume that only one register access happens per cycle. This means no operation can start while a write is being held. The bench drives every access through tasks that present one request at a time and hold it through any stall. It changes the bus only away from the active edge. It starts a new operation only after reading back the previous result or waiting long enough for it to complete.

// File: rtl/mac16_unit.sv
module mac16_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_stall
);
  localparam logic [3:0] A_CTRL = 4'd0, A_AL = 4'd1, A_AH = 4'd2, A_BL = 4'd3,
                         A_BH = 4'd4, A_R0 = 4'd5, A_R3 = 4'd8;
  localparam logic [2:0] IDLE = 3'd4;

  logic        dly32, dly_on, b_wide, a_wide, sat, frac, carry;
  logic [1:0]  mode;
  logic [31:0] opa, opb;
  logic [63:0] acc, shown;
  logic [2:0]  lvl;

  logic        wr, start, sgn, accm, ovf, new_carry;
  logic [31:0] opb_new;
  logic [63:0] a64, b64, prod, prod_f, new_res;
  logic [64:0] sum;
  logic [1:0]  ridx;

  assign sgn  = mode[0];
  assign accm = mode[1];

  assign bus_stall = bus_sel & bus_we & dly_on & (dly32 ? (lvl < 3'd2) : (lvl != IDLE));
  assign wr    = bus_sel & bus_we & ~bus_stall;
  assign start = wr & ((bus_addr == A_BL & ~b_wide) | (bus_addr == A_BH & b_wide));

  assign opb_new = (bus_addr == A_BH) ? {bus_wdata, opb[15:0]} : {opb[31:16], bus_wdata};

  assign a64 = a_wide ? {{32{sgn & opa[31]}}, opa}
                      : {{48{sgn & opa[15]}}, opa[15:0]};
  assign b64 = b_wide ? {{32{sgn & opb_new[31]}}, opb_new}
                      : {{48{sgn & opb_new[15]}}, opb_new[15:0]};

  assign prod   = a64 * b64;
  assign prod_f = frac ? {prod[62:0], 1'b0} : prod;

  assign sum = {sgn & prod_f[63], prod_f}
             + (accm ? {sgn & acc[63], acc} : 65'd0);

  assign ovf = sgn & accm & sat & (sum[64] ^ sum[63]);

  always_comb begin
    if (ovf) new_res = sum[64] ? {1'b1, 63'd0} : {1'b0, {63{1'b1}}};
    else     new_res = sum[63:0];
  end

  assign new_carry = (frac | sat) ? carry : sum[64];
  assign ridx      = 2'(bus_addr - A_R0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly32  <= 1'b0;
      dly_on <= 1'b0;
      b_wide <= 1'b0;
      a_wide <= 1'b0;
      mode   <= 2'b00;
      sat    <= 1'b0;
      frac   <= 1'b0;
      carry  <= 1'b0;
      opa    <= '0;
      opb    <= '0;
      acc    <= '0;
      shown  <= '0;
      lvl    <= IDLE;
    end else begin
      if (start) begin
        acc   <= new_res;
        carry <= new_carry;
        lvl   <= 3'd0;
      end else if (lvl != IDLE) begin
        shown[lvl[1:0]*16 +: 16] <= acc[lvl[1:0]*16 +: 16];
        lvl <= lvl + 3'd1;
      end
      if (wr) begin
        if (bus_addr == A_CTRL) begin
          dly32  <= bus_wdata[9];
          dly_on <= bus_wdata[8];
          b_wide <= bus_wdata[7];
          a_wide <= bus_wdata[6];
          mode   <= bus_wdata[5:4];
          sat    <= bus_wdata[3];
          frac   <= bus_wdata[2];
          carry  <= bus_wdata[0];
        end
        if (bus_addr == A_AL) opa[15:0]  <= bus_wdata;
        if (bus_addr == A_AH) opa[31:16] <= bus_wdata;
        if (bus_addr == A_BL) opb[15:0]  <= bus_wdata;
        if (bus_addr == A_BH) opb[31:16] <= bus_wdata;
        if (bus_addr >= A_R0 && bus_addr <= A_R3) begin
          acc[ridx*16 +: 16]   <= bus_wdata;
          shown[ridx*16 +: 16] <= bus_wdata;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {6'd0, dly32, dly_on, b_wide, a_wide, mode, sat, frac, 1'b0, carry};
      A_AL:    bus_rdata = opa[15:0];
      A_AH:    bus_rdata = opa[31:16];
      A_BL:    bus_rdata = opb[15:0];
      A_BH:    bus_rdata = opb[31:16];
      4'd5:    bus_rdata = shown[15:0];
      4'd6:    bus_rdata = shown[31:16];
      4'd7:    bus_rdata = shown[47:32];
      A_R3:    bus_rdata = shown[63:48];
      default: bus_rdata = 16'd0;
    endcase
  end
endmodule

module mac16_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_rdata,
  input logic        bus_stall,
  input logic        start,
  input logic [2:0]  lvl,
  input logic        frac,
  input logic        sat,
  input logic        carry
);
  logic [3:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 4'd0;
    else        run <= bus_stall ? run + 4'd1 : 4'd0;
  end

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 4'd0) |-> (bus_rdata[15:10] == 6'd0 && bus_rdata[1] == 1'b0));

  assert_stall_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> (bus_sel && bus_we));

  assert_stall_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 4'd4);

  assert_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (frac || sat)) |=> $stable(carry));

  assert_word_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && lvl < 3'd4) |=> lvl == 3'($past(lvl) + 3'd1));

  assert_start_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> lvl == 3'd0);
endmodule

bind mac16_unit mac16_unit_chk chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_stall(bus_stall), .start(start), .lvl(lvl),
  .frac(frac), .sat(sat), .carry(carry)
);

// File: tb/mac16_unit_test.sv
module mac16_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic bus_stall;

  int checks = 0, errors = 0, nst = 0;
  logic done = 1'b0;

  mac16_unit uut (.*);

  always #5 clk = ~clk;

  // ctrl, operand A, operand B, expected result, expected carry
  localparam int NV = 9;
  localparam logic [144:0] VEC [NV] = '{
    {16'h0000, 32'h0000FFFF, 32'h0000FFFF, 64'h00000000FFFE0001, 1'b0},
    {16'h0010, 32'h0000FFFF, 32'h00000002, 64'hFFFFFFFFFFFFFFFE, 1'b1},
    {16'h00C0, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFE00000001, 1'b0},
    {16'h0050, 32'h80000000, 32'h00000003, 64'hFFFFFFFE80000000, 1'b1},
    {16'h0005, 32'h00004000, 32'h00004000, 64'h0000000020000000, 1'b1},
    {16'h0020, 32'h00000010, 32'h00000010, 64'h0000000020000100, 1'b0},
    {16'h0030, 32'h0000FFFF, 32'h00000001, 64'h00000000200000FF, 1'b0},
    {16'h00D0, 32'hFFFFFFFE, 32'h80000000, 64'h0000000100000000, 1'b0},
    {16'h0080, 32'h1234FFFF, 32'h00010000, 64'h00000000FFFF0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    nst = 0;
    while (bus_stall) begin
      @(negedge clk); #1;
      nst++;
    end
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_res(output logic [63:0] r);
    logic [15:0] w;
    for (int k = 0; k < 4; k++) begin
      rd(4'(5 + k), w);
      r[k*16 +: 16] = w;
    end
  endtask

  task automatic preload(input logic [63:0] v);
    for (int k = 0; k < 4; k++) wr(4'(5 + k), v[k*16 +: 16]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [63:0] r;
    logic [15:0] c;
    logic [31:0] oa, ob;
    logic [63:0] er;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, w);  chk("R1 ctrl reset", 64'(w), 64'h0);
    rd_res(r);    chk("R1 result reset", r, 64'h0);
    // R1 reserved bits, R2 field layout
    wr(4'd0, 16'hFFF3);
    rd(4'd0, w);  chk("R1 R2 reserved read zero", 64'(w), 64'h03F1);
    wr(4'd0, 16'h0000);
    // R6 carry writable
    wr(4'd0, 16'h0001);
    rd(4'd0, w);  chk("R6 carry write", 64'(w), 64'h0001);
    wr(4'd0, 16'h0000);

    // table: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      c  = VEC[i][144:129];
      oa = VEC[i][128:97];
      ob = VEC[i][96:65];
      er = VEC[i][64:1];
      wr(4'd0, c);
      wr(4'd1, oa[15:0]);
      wr(4'd2, oa[31:16]);
      if (c[7]) begin
        wr(4'd3, ob[15:0]);
        wr(4'd4, ob[31:16]);
      end else begin
        wr(4'd3, ob[15:0]);
      end
      repeat (5) @(negedge clk);
      rd_res(r);
      chk($sformatf("R3 R4 R6 vector %0d result", i), r, er);
      rd(4'd0, w);
      chk($sformatf("R5 R6 vector %0d carry", i), 64'(w[0]), 64'(VEC[i][0]));
    end

    // R4 R5 unsigned accumulate carry out
    wr(4'd0, 16'h0020);
    preload(64'hFFFFFFFFFFFFFFFF);
    wr(4'd1, 16'h0001);
    wr(4'd3, 16'h0001);
    repeat (5) @(negedge clk);
    rd_res(r);    chk("R4 wrap result", r, 64'h0);
    rd(4'd0, w);  chk("R5 accumulate carry", 64'(w[0]), 64'h1);

    // R7 positive saturation, carry held at 0
    wr(4'd0, 16'h0038);
    preload(64'h7FFFFFFFFFFFFFFF);
    wr(4'd1, 16'h0001);
    wr(4'd3, 16'h0001);
    repeat (5) @(negedge clk);
    rd_res(r);    chk("R7 positive clamp", r, 64'h7FFFFFFFFFFFFFFF);
    rd(4'd0, w);  chk("R6 carry held under saturate", 64'(w[0]), 64'h0);

    // R7 negative saturation
    preload(64'h8000000000000000);
    wr(4'd1, 16'hFFFF);
    wr(4'd3, 16'h0001);
    repeat (5) @(negedge clk);
    rd_res(r);    chk("R7 negative clamp", r, 64'h8000000000000000);

    // R8 word timing, interlock off (R10)
    wr(4'd0, 16'h00C0);
    preload(64'h0);
    wr(4'd1, 16'hFFFF);
    wr(4'd2, 16'hFFFF);
    wr(4'd3, 16'hFFFF);
    chk("R10 no stall when off", 64'(nst), 64'h0);
    wr(4'd4, 16'hFFFF);
    chk("R10 start not stalled", 64'(nst), 64'h0);
    rd(4'd5, w);  chk("R8 word0 one edge after start still old", 64'(w), 64'h0);
    rd(4'd5, w);  chk("R8 word0 new", 64'(w), 64'h0001);
    rd(4'd8, w);  chk("R8 word3 old at third edge", 64'(w), 64'h0);
    rd(4'd8, w);  chk("R8 word3 old at fourth negedge", 64'(w), 64'h0);
    rd(4'd8, w);  chk("R8 word3 new", 64'(w), 64'hFFFF);

    // R9 interlock to 64 bits
    wr(4'd0, 16'h0100);
    wr(4'd1, 16'h0003);
    wr(4'd3, 16'h0005);
    wr(4'd1, 16'h0777);
    chk("R9 stall 64-bit point", 64'(nst), 64'h4);
    rd(4'd1, w);  chk("R9 held write lands", 64'(w), 64'h0777);
    rd_res(r);    chk("R9 result intact", r, 64'h000000000000000F);

    // R9 interlock to 32 bits
    wr(4'd0, 16'h0380);
    preload(64'h0);
    wr(4'd1, 16'h0002);
    wr(4'd3, 16'h0000);
    wr(4'd4, 16'h8000);
    wr(4'd2, 16'h1111);
    chk("R9 stall 32-bit point", 64'(nst), 64'h2);
    rd(4'd8, w);  chk("R9 R8 upper word still pending", 64'(w), 64'h0);
    repeat (3) @(negedge clk);
    rd_res(r);    chk("R9 final result", r, 64'h0000000100000000);
    rd(4'd2, w);  chk("R9 held write lands 32", 64'(w), 64'h1111);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule